// File: doc/BRIEF.md
# PCIe Interrupt Status Aggregator

This block gathers the interrupt events seen by a PCIe root port and folds them into one interrupt line for the host processor. The events it takes in are:

- pulses from the four legacy interrupt lines (INTA to INTD), one pulse when a line asserts and one when it deasserts;
- message-signalled interrupts (MSI), each arriving as a single-cycle event with a vector index and an 8-bit data byte;
- two link side events: a power-state change and a flush.

Every event lands in a sticky status bit. Each status bit stays set until software clears it by writing a 1 to it.

The status is arranged in three tiers, each with its own mask:

- **MSI tier.** A per-vector MSI status register holds one bit per vector. Any vector that is set and not masked keeps a pending bit alive in the main interrupt status register.
- **Main tier.** Any unmasked bit of the main interrupt status register keeps a core bit alive in the host status register.
- **Host tier.** The output interrupt is the OR of all host status bits that are not masked.

Each tier adds one registered cycle on the way up. Software reads the registers to find the cause, clears bits from the bottom tier upward, and reads the data byte of the most recent MSI from a payload register.

A simple single-cycle register port reaches all eight registers. Reads are combinational from the address. A write takes effect at the clock edge where the write strobe is high.

Top module: `pcie_irq_collector`

## Requirements
- R1: After reset, the register contents are as follows, and `irq_o` is 0:
  - every status register reads 0 and the payload register reads 0;
  - the main-status mask reads 0x07FFFFFF;
  - the MSI mask reads 0xFFFFFFFF;
  - the host mask reads 0x00FFF0FB.
- R2: A pulse on `intx_assert[n]` (n = 0..3) sets bit 16+n of the main status register (address 0). A pulse on `intx_deassert[n]` sets bit 20+n. The bit is visible on the clock edge that samples the pulse.
- R3: An MSI event with index v sets bit v of the MSI status register (address 2) on the sampling edge. At that same edge the payload register (address 4) captures the 8-bit data in bits 7:0 and reads 0 in bits 31:8.
- R4: One cycle after an MSI vector is set in MSI status and clear in the MSI mask (address 3), bit 24 of main status is set. The bit stays set on every edge at which such a vector exists. A masked vector never sets bit 24.
- R5: One cycle after any main status bit is set while its bit in the main-status mask (address 1) is 0, bit 16 of the host status register (address 5) is set. The bit stays set on every edge at which such a bit exists.
- R6: `irq_o` is 1 exactly when some host status bit is 1 while its bit in the host mask (address 6) is 0. It follows a mask write with no extra cycle.
- R7: The status registers at addresses 0, 2, 5 and 7 are write-one-to-clear:
  - a 1 in the write data clears that bit and a 0 leaves it unchanged;
  - bits outside the valid set always read 0 (valid sets: main 26:0, host 0x00FFF0FB, side-event 5:4).
- R8: When an event that sets a status bit arrives on the same edge as a write of 1 to that bit, the bit ends up set.
- R9: A `pm_event` pulse sets bit 4 and a `flush_event` pulse sets bit 5 of the side-event register (address 7). These bits feed neither the host status nor `irq_o`.
- R10: The mask registers keep only their valid bits (main mask 26:0, host mask 0x00FFF0FB, MSI mask all 32). The payload register is read-only: a write to address 4 leaves it unchanged.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside the block |
| intx_assert | input | 4 | Assert pulses for legacy lines A to D |
| intx_deassert | input | 4 | Deassert pulses for legacy lines A to D |
| msi_valid | input | 1 | One-cycle MSI arrival strobe |
| msi_vector | input | 5 | Vector index of the arriving MSI |
| msi_payload | input | 8 | Data byte of the arriving MSI |
| pm_event | input | 1 | Power-state change pulse |
| flush_event | input | 1 | Flush pulse |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address (0 main status, 1 main mask, 2 MSI status, 3 MSI mask, 4 payload, 5 host status, 6 host mask, 7 side events) |
| reg_wdata | input | 32 | Register write data |
| reg_rdata | output | 32 | Register read data for `reg_addr` |
| irq_o | output | 1 | Summary interrupt |

## Verification
The assertions check the following on every cycle:
- a setting event always leaves its bit set on the next edge, whatever is written at the same edge;
- a register with neither a write nor an event holds its value;
- each tier propagates into the tier above one cycle later;
- the payload register captures each MSI data byte.

Only the bench's scenarios show the rest:
- the register map and the write-one-to-clear readback values;
- masks that hold a tier back;
- the side events staying out of the summary line;
- the ordering software needs when clearing, since clearing an upper bit while a lower cause is still active has no lasting effect.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

  typedef enum logic [2:0] {
    SEL_MAIN_STAT = 3'd0,
    SEL_MAIN_MASK = 3'd1,
    SEL_MSI_STAT  = 3'd2,
    SEL_MSI_MASK  = 3'd3,
    SEL_MSI_DATA  = 3'd4,
    SEL_HOST_STAT = 3'd5,
    SEL_HOST_MASK = 3'd6,
    SEL_SIDE_STAT = 3'd7
  } reg_sel_e;

  localparam logic [31:0] MAIN_VALID = 32'h07FF_FFFF;
  localparam logic [31:0] HOST_VALID = 32'h00FF_F0FB;
  localparam logic [31:0] SIDE_VALID = 32'h0000_0030;

  localparam int LEG_ASSERT_LSB   = 16;
  localparam int LEG_DEASSERT_LSB = 20;
  localparam int MSI_PEND_BIT     = 24;
  localparam int CORE_BIT         = 16;
  localparam int PM_BIT           = 4;
  localparam int FLUSH_BIT        = 5;

endpackage

// File: rtl/irq_w1c_bank.sv
module irq_w1c_bank #(
  parameter int           W     = 32,
  parameter logic [W-1:0] VALID = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] set_i,
  input  logic         clr_en,
  input  logic [W-1:0] clr_bits,
  output logic [W-1:0] stat_q
);

  logic [W-1:0] clr_mask;
  logic [W-1:0] stat_d;
  logic         stat_en;

  // set terms are ORed after the clear so an event always wins
  always_comb begin
    clr_mask = clr_en ? clr_bits : '0;
    stat_d   = ((stat_q & ~clr_mask) | set_i) & VALID;
    stat_en  = clr_en | (|set_i);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stat_q <= '0;
    else if (stat_en) stat_q <= stat_d;
  end

  p_set_wins_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (|(set_i & VALID)) |=> ((stat_q & $past(set_i & VALID)) == $past(set_i & VALID)));

  p_hold_idle_r7: assert property (@(posedge clk) disable iff (!rst_n)
    (!clr_en && set_i == '0) |=> $stable(stat_q));

endmodule

// File: rtl/irq_mask_bank.sv
module irq_mask_bank #(
  parameter int           W       = 32,
  parameter logic [W-1:0] VALID   = '1,
  parameter logic [W-1:0] RST_VAL = '1
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         wr_en,
  input  logic [W-1:0] wdata,
  output logic [W-1:0] mask_q
);

  logic [W-1:0] mask_d;

  always_comb mask_d = wdata & VALID;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)     mask_q <= RST_VAL & VALID;
    else if (wr_en) mask_q <= mask_d;
  end

  p_mask_hold_r10: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(mask_q));

endmodule

// File: rtl/pcie_irq_collector.sv
module pcie_irq_collector
  import irq_agg_pkg::*;
#(
  parameter int  NUM_INTX    = 4,
  parameter int  MSI_VECTORS = 32,
  parameter int  PAYLOAD_W   = 8,
  parameter int  DATA_W      = 32,
  parameter int  ADDR_W      = 3,
  localparam int VEC_W       = $clog2(MSI_VECTORS)
) (
  input  logic                 clk,
  input  logic                 rst_n,
  input  logic [NUM_INTX-1:0]  intx_assert,
  input  logic [NUM_INTX-1:0]  intx_deassert,
  input  logic                 msi_valid,
  input  logic [VEC_W-1:0]     msi_vector,
  input  logic [PAYLOAD_W-1:0] msi_payload,
  input  logic                 pm_event,
  input  logic                 flush_event,
  input  logic                 reg_wr,
  input  logic [ADDR_W-1:0]    reg_addr,
  input  logic [DATA_W-1:0]    reg_wdata,
  output logic [DATA_W-1:0]    reg_rdata,
  output logic                 irq_o
);

  localparam int NUM_REGS = 1 << ADDR_W;

  // reset: asynchronous assert, synchronous release
  logic [1:0] rst_pipe;
  logic       rst_sync_n;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) rst_pipe <= '0;
    else        rst_pipe <= {rst_pipe[0], 1'b1};
  end
  assign rst_sync_n = rst_pipe[1];

  // write decode
  logic [NUM_REGS-1:0] wr_sel;
  for (genvar k = 0; k < NUM_REGS; k++) begin : g_wsel
    assign wr_sel[k] = reg_wr && (reg_addr == ADDR_W'(k));
  end

  logic [DATA_W-1:0]      main_stat, main_mask, host_stat, host_mask, side_stat;
  logic [MSI_VECTORS-1:0] msi_stat, msi_mask;
  logic [DATA_W-1:0]      main_set, host_set, side_set;
  logic [MSI_VECTORS-1:0] msi_set, msi_eff;
  logic [DATA_W-1:0]      main_act;
  logic [PAYLOAD_W-1:0]   payload_q, payload_d;

  // set vectors for each tier
  always_comb begin
    msi_set = '0;
    if (msi_valid) msi_set[msi_vector] = 1'b1;
    msi_eff = msi_stat & ~msi_mask;

    main_set = '0;
    main_set[LEG_ASSERT_LSB   +: NUM_INTX] = intx_assert;
    main_set[LEG_DEASSERT_LSB +: NUM_INTX] = intx_deassert;
    main_set[MSI_PEND_BIT]                 = |msi_eff;
    main_act = main_stat & ~main_mask;

    host_set = '0;
    host_set[CORE_BIT] = |main_act;

    side_set = '0;
    side_set[PM_BIT]    = pm_event;
    side_set[FLUSH_BIT] = flush_event;

    payload_d = msi_payload;
  end

  irq_w1c_bank #(.W(MSI_VECTORS), .VALID('1)) u_msi_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(msi_set),
    .clr_en(wr_sel[SEL_MSI_STAT]), .clr_bits(reg_wdata[MSI_VECTORS-1:0]),
    .stat_q(msi_stat));

  irq_w1c_bank #(.W(DATA_W), .VALID(MAIN_VALID)) u_main_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(main_set),
    .clr_en(wr_sel[SEL_MAIN_STAT]), .clr_bits(reg_wdata), .stat_q(main_stat));

  irq_w1c_bank #(.W(DATA_W), .VALID(HOST_VALID)) u_host_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(host_set),
    .clr_en(wr_sel[SEL_HOST_STAT]), .clr_bits(reg_wdata), .stat_q(host_stat));

  irq_w1c_bank #(.W(DATA_W), .VALID(SIDE_VALID)) u_side_stat (
    .clk(clk), .rst_n(rst_sync_n), .set_i(side_set),
    .clr_en(wr_sel[SEL_SIDE_STAT]), .clr_bits(reg_wdata), .stat_q(side_stat));

  irq_mask_bank #(.W(MSI_VECTORS), .VALID('1), .RST_VAL('1)) u_msi_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_sel[SEL_MSI_MASK]),
    .wdata(reg_wdata[MSI_VECTORS-1:0]), .mask_q(msi_mask));

  irq_mask_bank #(.W(DATA_W), .VALID(MAIN_VALID), .RST_VAL(MAIN_VALID)) u_main_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_sel[SEL_MAIN_MASK]),
    .wdata(reg_wdata), .mask_q(main_mask));

  irq_mask_bank #(.W(DATA_W), .VALID(HOST_VALID), .RST_VAL(HOST_VALID)) u_host_mask (
    .clk(clk), .rst_n(rst_sync_n), .wr_en(wr_sel[SEL_HOST_MASK]),
    .wdata(reg_wdata), .mask_q(host_mask));

  always_ff @(posedge clk or negedge rst_sync_n) begin
    if (!rst_sync_n)    payload_q <= '0;
    else if (msi_valid) payload_q <= payload_d;
  end

  assign irq_o = |(host_stat & ~host_mask);

  always_comb begin
    unique case (reg_sel_e'(reg_addr))
      SEL_MAIN_STAT: reg_rdata = main_stat;
      SEL_MAIN_MASK: reg_rdata = main_mask;
      SEL_MSI_STAT:  reg_rdata = DATA_W'(msi_stat);
      SEL_MSI_MASK:  reg_rdata = DATA_W'(msi_mask);
      SEL_MSI_DATA:  reg_rdata = DATA_W'(payload_q);
      SEL_HOST_STAT: reg_rdata = host_stat;
      SEL_HOST_MASK: reg_rdata = host_mask;
      SEL_SIDE_STAT: reg_rdata = side_stat;
      default:       reg_rdata = '0;
    endcase
  end

  p_legacy_set_r2: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|intx_assert) |=> ((main_stat[LEG_ASSERT_LSB +: NUM_INTX] & $past(intx_assert))
                        == $past(intx_assert)));

  p_msi_set_r3: assert property (@(posedge clk) disable iff (!rst_sync_n)
    msi_valid |=> (msi_stat[$past(msi_vector)] && payload_q == $past(msi_payload)));

  p_msi_rollup_r4: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(msi_stat & ~msi_mask)) |=> main_stat[MSI_PEND_BIT]);

  p_core_rollup_r5: assert property (@(posedge clk) disable iff (!rst_sync_n)
    (|(main_stat & ~main_mask)) |=> host_stat[CORE_BIT]);

endmodule

// File: tb/pcie_irq_collector_bench.sv
module pcie_irq_collector_bench;

  logic        clk = 1'b0;
  logic        rst_n;
  logic [3:0]  intx_assert, intx_deassert;
  logic        msi_valid;
  logic [4:0]  msi_vector;
  logic [7:0]  msi_payload;
  logic        pm_event, flush_event;
  logic        reg_wr;
  logic [2:0]  reg_addr;
  logic [31:0] reg_wdata, reg_rdata;
  logic        irq_o;

  int checks = 0;
  int fails  = 0;
  bit done   = 0;

  always #2 clk = ~clk;

  pcie_irq_collector u_pcie_irq_collector (
    .clk(clk), .rst_n(rst_n), .intx_assert(intx_assert), .intx_deassert(intx_deassert),
    .msi_valid(msi_valid), .msi_vector(msi_vector), .msi_payload(msi_payload),
    .pm_event(pm_event), .flush_event(flush_event), .reg_wr(reg_wr),
    .reg_addr(reg_addr), .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .irq_o(irq_o));

  task automatic step();
    @(posedge clk);
    #1;
  endtask

  task automatic wr(input logic [2:0] a, input logic [31:0] d);
    reg_wr = 1'b1; reg_addr = a; reg_wdata = d;
    step();
    reg_wr = 1'b0; reg_wdata = '0;
  endtask

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s: got %h expected %h", tag, got, exp);
    end
  endtask

  task automatic rdchk(input string tag, input logic [2:0] a, input logic [31:0] exp);
    reg_addr = a;
    #1;
    chk(tag, reg_rdata, exp);
  endtask

  task automatic msi_ev(input logic [4:0] v, input logic [7:0] p);
    msi_valid = 1'b1; msi_vector = v; msi_payload = p;
    step();
    msi_valid = 1'b0;
  endtask

  initial begin
    #(4 * 200000);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog: got hung expected finish");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end

  initial begin
    logic [31:0] exp;
    rst_n = 1'b0; intx_assert = '0; intx_deassert = '0; msi_valid = 1'b0;
    msi_vector = '0; msi_payload = '0; pm_event = 1'b0; flush_event = 1'b0;
    reg_wr = 1'b0; reg_addr = '0; reg_wdata = '0;
    repeat (3) step();
    rst_n = 1'b1;
    repeat (3) step();

    // R1 reset state
    rdchk("R1 main stat", 3'd0, 32'h0);
    rdchk("R1 main mask", 3'd1, 32'h07FF_FFFF);
    rdchk("R1 msi stat",  3'd2, 32'h0);
    rdchk("R1 msi mask",  3'd3, 32'hFFFF_FFFF);
    rdchk("R1 payload",   3'd4, 32'h0);
    rdchk("R1 host stat", 3'd5, 32'h0);
    rdchk("R1 host mask", 3'd6, 32'h00FF_F0FB);
    rdchk("R1 side stat", 3'd7, 32'h0);
    chk("R1 irq", {31'b0, irq_o}, 32'h0);

    // R2 legacy sweep
    exp = 0;
    for (int n = 0; n < 4; n++) begin
      intx_assert = 4'(1 << n); step(); intx_assert = '0;
      exp |= 32'(1) << (16 + n);
      rdchk("R2 assert", 3'd0, exp);
      intx_deassert = 4'(1 << n); step(); intx_deassert = '0;
      exp |= 32'(1) << (20 + n);
      rdchk("R2 deassert", 3'd0, exp);
    end
    rdchk("R5 masked main keeps host clear", 3'd5, 32'h0);

    // R7 write-one-to-clear
    wr(3'd0, 32'h0001_0000);
    rdchk("R7 clear one bit", 3'd0, 32'h00FE_0000);
    wr(3'd0, 32'h0);
    rdchk("R7 zero write keeps", 3'd0, 32'h00FE_0000);
    wr(3'd0, 32'hFFFF_FFFF);
    rdchk("R7 clear all", 3'd0, 32'h0);

    // R3 MSI sweep with all vectors masked
    exp = 0;
    for (int v = 0; v < 32; v++) begin
      msi_ev(5'(v), 8'((v * 37 + 11) & 8'hFF));
      exp |= 32'(1) << v;
      rdchk("R3 msi stat", 3'd2, exp);
      rdchk("R3 payload", 3'd4, 32'((v * 37 + 11) & 8'hFF));
    end
    step(); step();
    rdchk("R4 masked vectors no pending", 3'd0, 32'h0);
    wr(3'd2, 32'hFFFF_FFFF);
    rdchk("R7 msi clear all", 3'd2, 32'h0);

    // R4 roll-up for selected vectors
    foreach (exp[i]) begin
      if (i == 0 || i == 13 || i == 31) begin
        wr(3'd3, ~(32'(1) << i));
        msi_ev(5'((i + 1) % 32), 8'h5A);
        step(); step();
        rdchk("R4 masked neighbour", 3'd0, 32'h0);
        wr(3'd2, 32'hFFFF_FFFF);
        msi_ev(5'(i), 8'hC3);
        rdchk("R4 not yet", 3'd0, 32'h0);
        step();
        rdchk("R4 pending", 3'd0, 32'h0100_0000);
        wr(3'd0, 32'h0100_0000);
        rdchk("R4 stays while effective", 3'd0, 32'h0100_0000);
        wr(3'd2, 32'(1) << i);
        rdchk("R7 msi vector cleared", 3'd2, 32'h0);
        wr(3'd0, 32'h0100_0000);
        rdchk("R4 clears after vector", 3'd0, 32'h0);
        wr(3'd3, 32'hFFFF_FFFF);
      end
    end

    // R5 / R6 host tier
    wr(3'd1, 32'h07FE_FFFF);
    intx_deassert = 4'h1; step(); intx_deassert = '0;
    step(); step();
    rdchk("R5 masked bit no core", 3'd5, 32'h0);
    wr(3'd0, 32'hFFFF_FFFF);
    intx_assert = 4'h1; step(); intx_assert = '0;
    rdchk("R5 core not yet", 3'd5, 32'h0);
    step();
    rdchk("R5 core set", 3'd5, 32'h0001_0000);
    chk("R6 host masked irq low", {31'b0, irq_o}, 32'h0);
    wr(3'd6, 32'h00FE_F0FB);
    chk("R6 irq after unmask", {31'b0, irq_o}, 32'h1);
    wr(3'd5, 32'h0001_0000);
    rdchk("R5 core holds while main active", 3'd5, 32'h0001_0000);
    wr(3'd0, 32'h0001_0000);
    rdchk("R7 main cleared", 3'd0, 32'h0);
    wr(3'd5, 32'hFFFF_FFFF);
    rdchk("R7 host cleared", 3'd5, 32'h0);
    chk("R6 irq low after clear", {31'b0, irq_o}, 32'h0);

    // R8 set wins over clear
    intx_assert = 4'h2; step(); intx_assert = '0;
    intx_assert = 4'h2; wr(3'd0, 32'h0002_0000); intx_assert = '0;
    rdchk("R8 main set wins", 3'd0, 32'h0002_0000);
    wr(3'd0, 32'h0002_0000);
    rdchk("R8 main clears later", 3'd0, 32'h0);
    msi_ev(5'd3, 8'h11);
    msi_valid = 1'b1; msi_vector = 5'd3; msi_payload = 8'h22;
    wr(3'd2, 32'h8);
    msi_valid = 1'b0;
    rdchk("R8 msi set wins", 3'd2, 32'h8);
    rdchk("R3 payload latest", 3'd4, 32'h22);
    wr(3'd2, 32'h8);
    rdchk("R8 msi clears later", 3'd2, 32'h0);

    // R9 side events
    pm_event = 1'b1; step(); pm_event = 1'b0;
    rdchk("R9 power bit", 3'd7, 32'h10);
    flush_event = 1'b1; step(); flush_event = 1'b0;
    rdchk("R9 flush bit", 3'd7, 32'h30);
    step(); step();
    rdchk("R9 no host effect", 3'd5, 32'h0);
    chk("R9 no irq", {31'b0, irq_o}, 32'h0);
    wr(3'd7, 32'h10);
    rdchk("R7 side clear one", 3'd7, 32'h20);
    wr(3'd7, 32'hFFFF_FFFF);
    rdchk("R7 side clear all", 3'd7, 32'h0);

    // R10 masks and read-only payload
    wr(3'd4, 32'hAB);
    rdchk("R10 payload write ignored", 3'd4, 32'h22);
    wr(3'd1, 32'hFFFF_FFFF);
    rdchk("R10 main mask valid bits", 3'd1, 32'h07FF_FFFF);
    wr(3'd6, 32'hFFFF_FFFF);
    rdchk("R10 host mask valid bits", 3'd6, 32'h00FF_F0FB);
    wr(3'd3, 32'h1234_5678);
    rdchk("R10 msi mask full width", 3'd3, 32'h1234_5678);

    done = 1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

endmodule